// File: doc/BRIEF.md
# Edge-Latched-Address Scratch RAM

A small synchronous read/write store of 16 words of 4 bits. Accesses are framed by an active-low enable. When the enable goes from high to low, the block takes the address presented in that cycle into an internal register. Every later read or write in that enabled window goes to the registered word, so the address bus is free to move on once the window has opened.

The active-low write strobe selects the operation inside the window. With the strobe low, the data inputs are stored. With the strobe high, the block drives out the bitwise inverse of the selected word and raises an output-enable flag. A read followed by a write in one window forms a read-modify-write on the same word. While the enable is high, the store keeps its contents and the output is off. The output-enable flag is meant to drive a tri-state buffer outside the block, so the core uses no tri-state logic.

A small state machine holds the access mode. It has three states: `ST_OFF` (idle), `ST_READ` and `ST_WRITE`. At every clock edge it loads the mode that the sampled enables select. The enable high selects `ST_OFF`. Both enables low select `ST_WRITE`. The enable low with the write strobe high selects `ST_READ`. Every transition between any two of these states is possible and follows only these inputs.

Top module: `latram_top`

## Requirements
- R1: After reset `dout_oe` is 0, `dout` is 0, and the block is in `ST_OFF`.
- R2: The address register loads `addr` only at a clock edge where `mem_en_n` is sampled 0 and was sampled 1 at the previous edge (reset counts as 1). Changes on `addr` later in the same window do not change which word is read or written.
- R3: At a clock edge where `mem_en_n` and `wr_en_n` are both sampled 0, `din` is stored at the word that R2 selects. At the window's first edge, this is the address present in that same cycle.
- R4: After an edge where `mem_en_n` is sampled 0 and `wr_en_n` is sampled 1, `dout_oe` is 1 and `dout` equals the bitwise inverse of the selected word.
- R5: After an edge where `mem_en_n` is sampled 1, `dout_oe` is 0. No word changes, whatever the values of `wr_en_n` and `din`.
- R6: After an edge where a write takes place, `dout_oe` is 0.
- R7: Reads are non-destructive. Any number of consecutive reads return the same value, and the word still holds that value in a later window.
- R8: Within one window, a read phase followed by a write phase targets the same latched word. A read in the cycle after the write returns the inverse of the new data.
- R9: Whenever `dout_oe` is 0, `dout` is driven to all zeros.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mem_en_n | input | 1 | Active-low access enable; its falling edge latches the address |
| wr_en_n | input | 1 | Active-low write strobe (high = read) |
| addr | input | ADDR_W | Word address, sampled only at the opening edge of a window |
| din | input | DATA_W | Write data |
| dout | output | DATA_W | Inverted read data, zero when not reading |
| dout_oe | output | 1 | High while in the read state; intended to drive an external tri-state |

## Verification
The bench builds the block with its default parameters, ADDR_W = 4 and DATA_W = 4. At this size every one of the 16 words can be written with a distinct pattern and read back, so a decode or inversion fault on any address bit shows up. The small space also makes it cheap to move the address bus inside a window, both during reads and during writes, and to confirm that the latched word is the one touched and that its neighbour is left intact. Read-modify-write, inhibited writes and repeated reads are each checked against a model that the bench keeps from the requirements.

// File: rtl/latram_pkg.sv
package latram_pkg;

    typedef enum logic [1:0] {
        ST_OFF   = 2'd0,
        ST_READ  = 2'd1,
        ST_WRITE = 2'd2
    } latram_state_e;

endpackage

// File: rtl/latram_ctrl.sv
module latram_ctrl
    import latram_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mem_en_n,
    input  logic              wr_en_n,
    input  logic [ADDR_W-1:0] addr_i,
    output latram_state_e     state_o,
    output logic [ADDR_W-1:0] rd_addr_o,
    output logic              wr_en_o,
    output logic [ADDR_W-1:0] wr_addr_o
);

    latram_state_e     state_q, state_d;
    logic              en_n_q;
    logic [ADDR_W-1:0] addr_q;
    logic              open_edge;

    // window opens when enable seen low now and high at the previous edge
    assign open_edge = en_n_q & ~mem_en_n;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_n_q <= 1'b1;
            addr_q <= '0;
        end else begin
            en_n_q <= mem_en_n;
            if (open_edge) begin
                addr_q <= addr_i;
            end
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OFF: begin
                if (!mem_en_n) state_d = wr_en_n ? ST_READ : ST_WRITE;
            end
            ST_READ: begin
                if (mem_en_n)     state_d = ST_OFF;
                else if (!wr_en_n) state_d = ST_WRITE;
            end
            ST_WRITE: begin
                if (mem_en_n)     state_d = ST_OFF;
                else if (wr_en_n) state_d = ST_READ;
            end
            default: state_d = ST_OFF;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_OFF;
        else        state_q <= state_d;
    end

    assign state_o   = state_q;
    assign rd_addr_o = addr_q;
    assign wr_en_o   = ~mem_en_n & ~wr_en_n;
    assign wr_addr_o = open_edge ? addr_i : addr_q;

    // R2
    addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_en_n && !en_n_q) |=> $stable(addr_q));

    // R2
    addr_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_en_n == 1'b0 && en_n_q) |=> (addr_q == $past(addr_i)));

endmodule

// File: rtl/latram_array.sv
module latram_array #(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 4
) (
    input  logic              clk,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic [ADDR_W-1:0] rd_addr_i,
    output logic [DATA_W-1:0] rd_data_o
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] words [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en_i) begin
            words[wr_addr_i] <= wr_data_i;
        end
    end

    assign rd_data_o = words[rd_addr_i];

endmodule

// File: rtl/latram_out.sv
module latram_out
    import latram_pkg::*;
#(
    parameter int DATA_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  latram_state_e     state_i,
    input  logic [DATA_W-1:0] rd_data_i,
    output logic [DATA_W-1:0] dout_o,
    output logic              oe_o
);

    always_comb begin
        dout_o = '0;
        oe_o   = 1'b0;
        unique case (state_i)
            ST_READ: begin
                dout_o = ~rd_data_i;
                oe_o   = 1'b1;
            end
            ST_WRITE, ST_OFF: begin
                dout_o = '0;
                oe_o   = 1'b0;
            end
            default: begin
                dout_o = '0;
                oe_o   = 1'b0;
            end
        endcase
    end

    // R9
    quiet_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !oe_o |-> (dout_o == '0));

endmodule

// File: rtl/latram_top.sv
module latram_top
    import latram_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mem_en_n,
    input  logic              wr_en_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout,
    output logic              dout_oe
);

    latram_state_e     state;
    logic [ADDR_W-1:0] rd_addr;
    logic              wr_en;
    logic [ADDR_W-1:0] wr_addr;
    logic [DATA_W-1:0] rd_data;

    latram_ctrl #(.ADDR_W(ADDR_W)) ctrl_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .mem_en_n  (mem_en_n),
        .wr_en_n   (wr_en_n),
        .addr_i    (addr),
        .state_o   (state),
        .rd_addr_o (rd_addr),
        .wr_en_o   (wr_en),
        .wr_addr_o (wr_addr)
    );

    latram_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) array_i (
        .clk       (clk),
        .wr_en_i   (wr_en),
        .wr_addr_i (wr_addr),
        .wr_data_i (din),
        .rd_addr_i (rd_addr),
        .rd_data_o (rd_data)
    );

    latram_out #(.DATA_W(DATA_W)) out_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .state_i   (state),
        .rd_data_i (rd_data),
        .dout_o    (dout),
        .oe_o      (dout_oe)
    );

    // R4
    read_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_en_n && wr_en_n) |=> dout_oe);

    // R5
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_en_n |=> !dout_oe);

    // R6
    write_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_en_n && !wr_en_n) |=> !dout_oe);

    // R4
    read_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_en_n && wr_en_n && $past(!mem_en_n && wr_en_n)) |=> $stable(dout));

endmodule

// File: tb/latram_top_tb_top.sv
module latram_top_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mem_en_n = 1'b1;
    logic       wr_en_n = 1'b1;
    logic [3:0] addr = '0;
    logic [3:0] din = '0;
    logic [3:0] dout;
    logic       dout_oe;

    int checks = 0;
    int failures = 0;
    logic [3:0] model [16];

    always #2.5 clk = ~clk;

    latram_top dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .mem_en_n (mem_en_n),
        .wr_en_n  (wr_en_n),
        .addr     (addr),
        .din      (din),
        .dout     (dout),
        .dout_oe  (dout_oe)
    );

    task automatic check(input string req, input logic [4:0] got, input logic [4:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s got=%h expected=%h", req, got, exp);
        end
    endtask

    // drive on the falling clock edge, observe 1 ns after the next rising edge
    task automatic step(input logic en, input logic we, input logic [3:0] a, input logic [3:0] d);
        @(negedge clk);
        mem_en_n = en;
        wr_en_n  = we;
        addr     = a;
        din      = d;
        @(posedge clk);
        #1;
    endtask

    task automatic do_write(input logic [3:0] a, input logic [3:0] d);
        step(1, 1, a, 4'h0);
        step(0, 0, a, d);
        model[a] = d;
        check("R6 write oe", {dout_oe, dout}, 5'h00);
        step(1, 1, a, 4'h0);
        check("R5 idle oe", {dout_oe, dout}, 5'h00);
    endtask

    task automatic do_read(input string req, input logic [3:0] a);
        step(1, 1, a, 4'h0);
        step(0, 1, a, 4'h0);
        check(req, {dout_oe, dout}, {1'b1, ~model[a]});
    endtask

    task automatic t_reset();
        check("R1 reset outputs", {dout_oe, dout}, 5'h00);
    endtask

    task automatic t_fill_all();
        for (int i = 0; i < 16; i++) do_write(4'(i), 4'(i ^ 4'h9));
        for (int i = 0; i < 16; i++) do_read("R3 R4 readback", 4'(i));
    endtask

    task automatic t_latch();
        do_write(4'h3, 4'hA);
        do_write(4'h9, 4'h6);
        step(1, 1, 4'h3, 4'h0);
        step(0, 1, 4'h3, 4'h0);
        step(0, 1, 4'h9, 4'h0);
        check("R2 read ignores addr move", {dout_oe, dout}, {1'b1, ~model[3]});
        step(1, 1, 4'h0, 4'h0);
        // write window opened on 5; addr moved to 12 for the second write beat
        do_write(4'hC, 4'h1);
        step(0, 0, 4'h5, 4'hE);
        step(0, 0, 4'hC, 4'h7);
        model[5] = 4'h7;
        do_read("R2 write went to latched word", 4'h5);
        do_read("R2 other word untouched", 4'hC);
    endtask

    task automatic t_inhibit();
        do_write(4'h7, 4'h2);
        step(1, 0, 4'h7, 4'hD);
        check("R5 inhibited oe", {dout_oe, dout}, 5'h00);
        check("R9 zero bus when off", {1'b0, dout}, 5'h00);
        step(1, 1, 4'h7, 4'hF);
        do_read("R5 word kept", 4'h7);
    endtask

    task automatic t_nondestructive();
        do_write(4'hB, 4'h5);
        step(1, 1, 4'hB, 4'h0);
        for (int k = 0; k < 5; k++) begin
            step(0, 1, 4'hB, 4'h0);
            check("R7 repeated read", {dout_oe, dout}, {1'b1, ~model[11]});
        end
        do_read("R7 later window", 4'hB);
    endtask

    task automatic t_rmw();
        do_write(4'h2, 4'h8);
        do_write(4'hD, 4'h4);
        step(1, 1, 4'h2, 4'h0);
        step(0, 1, 4'h2, 4'h0);
        check("R8 read phase", {dout_oe, dout}, {1'b1, ~model[2]});
        step(0, 0, 4'hD, 4'h3);
        model[2] = 4'h3;
        check("R6 rmw write phase oe", {dout_oe, dout}, 5'h00);
        step(0, 1, 4'hD, 4'h0);
        check("R8 read after write", {dout_oe, dout}, {1'b1, ~model[2]});
        do_read("R8 neighbour intact", 4'hD);
    endtask

    task automatic t_write_on_open();
        // first cycle of window writes, next cycle reads: R3 and R8 timing
        step(1, 1, 4'h0, 4'h0);
        step(0, 0, 4'hE, 4'hB);
        model[14] = 4'hB;
        step(0, 1, 4'h1, 4'h0);
        check("R3 write at opening edge", {dout_oe, dout}, {1'b1, ~model[14]});
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        t_reset();
        @(negedge clk);
        rst_n = 1'b1;
        fork
            begin
                t_fill_all();
                t_latch();
                t_inhibit();
                t_nondestructive();
                t_rmw();
                t_write_on_open();
            end
            begin
                repeat (20000) @(posedge clk);
                failures++;
                $display("FAIL watchdog expired");
            end
        join_any
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule